// File: doc/BRIEF.md
# Dual-Port Collision Arbiter with Write Inhibit

This block wraps a small two-ported storage array. It has a left port and a right port. Each port carries an enable, a write strobe, an address, write data and registered read data. When both ports are enabled on the same address in the same clock cycle, the block lets one port through and flags the other port as busy. It also suppresses the losing port's write, so the stored word cannot be corrupted by a contested access. Arbitration looks only at enables and addresses. Whether an access is a read or a write plays no part in the decision.

A mode input picks the role of the block. In master mode the block arbitrates and drives its two active-low busy outputs. Those outputs can be wired to other copies of the block that sit at the same addresses. In slave mode the block does no arbitration and holds its busy outputs high. Its two active-low busy inputs then act purely as per-port write inhibits. Tying one of them low makes that port read-only.

All decisions are made at the rising clock edge. A busy output reflects the decision taken for the accesses presented in the previous cycle. Reads are read-first: they return the word as it was before any write at that same edge.

Top module: `dp_collide_ram`

## Requirements
- R1: In master mode (`master_mode`=1), if in a cycle the two ports are not both enabled on the same address, both `l_busy_n_o` and `r_busy_n_o` are 1 after that clock edge.
- R2: In master mode, if both ports are enabled on the same address in a cycle, exactly one of `l_busy_n_o`/`r_busy_n_o` is 0 after that clock edge.
- R3: A conflict with no loser from the cycle before, where the right port was not already enabled on that same address the cycle before (or both ports were), is won by the left port: `r_busy_n_o` goes to 0.
- R4: When only the right port was enabled on the contested address the cycle before, the right port keeps the grant and `l_busy_n_o` goes to 0. While a conflict lasts over several cycles, the port that lost in the previous cycle loses again.
- R5: In master mode the losing port's write is dropped and the word keeps its value. The winning port's write is applied.
- R6: The write strobes have no effect on arbitration: the same enables and addresses give the same busy outputs for reads and for writes.
- R7: A port that loses arbitration still gets the stored word on its read data one cycle later.
- R8: In slave mode (`master_mode`=0) both busy outputs are held at 1, whatever the addresses.
- R9: In slave mode, a busy input at 0 blocks writes from that port and a busy input at 1 lets them through. A busy input held at 0 keeps that port from ever changing memory.
- R10: In master mode the busy inputs are ignored: an uncontested write always lands.
- R11: While `rst` is 1 and after its release, both busy outputs are 1 and both read data outputs are 0 until a read is done.
- R12: Read data is registered and read-first (it returns the word as it was before a same-edge write), and it holds its value while the port is disabled. When both ports write the same word with no inhibit, the left port's data is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| master_mode | input | 1 | 1 = arbitrate and drive busy, 0 = busy pins are write inhibits |
| l_en | input | 1 | Left port enable |
| l_we | input | 1 | Left port write strobe |
| l_addr | input | AW | Left port address |
| l_wdata | input | DW | Left port write data |
| l_rdata | output | DW | Left port registered read data |
| l_busy_n_i | input | 1 | Left write inhibit in slave mode, active low |
| l_busy_n_o | output | 1 | Left busy flag in master mode, active low |
| r_en | input | 1 | Right port enable |
| r_we | input | 1 | Right port write strobe |
| r_addr | input | AW | Right port address |
| r_wdata | input | DW | Right port write data |
| r_rdata | output | DW | Right port registered read data |
| r_busy_n_i | input | 1 | Right write inhibit in slave mode, active low |
| r_busy_n_o | output | 1 | Right busy flag in master mode, active low |

## Verification
Two kinds of internal fault are likely. A stale record of who held an address, or of who lost the previous cycle, shows up one edge later as the wrong busy pin going low. A wrong gating decision leaves a corrupted or missing word in the array. That fault stays hidden until the word is next read, and then it appears in read data one cycle after that read. The bench therefore checks busy and read data after every edge against an arithmetic model. It sweeps address, enable, strobe and inhibit patterns over a four-word window so that conflicts, hand-overs and persistent collisions recur often. It then reads the whole array back through both ports to expose any write that should or should not have landed.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  typedef enum logic [1:0] {
    VERDICT_NONE  = 2'd0,
    VERDICT_LEFT  = 2'd1,
    VERDICT_RIGHT = 2'd2
  } verdict_e;
endpackage

// File: rtl/dpc_arbiter.sv
module dpc_arbiter #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          master,
  input  logic          l_en,
  input  logic [AW-1:0] l_addr,
  input  logic          r_en,
  input  logic [AW-1:0] r_addr,
  output logic          lose_l,
  output logic          lose_r,
  output logic          l_busy_n_q,
  output logic          r_busy_n_q
);
  import dpc_pkg::*;

  logic          pl_en, pr_en;
  logic [AW-1:0] pl_addr, pr_addr;
  logic          clash, l_held, r_held;
  verdict_e      verdict;

  assign clash  = master && l_en && r_en && (l_addr == r_addr);
  assign l_held = pl_en && (pl_addr == l_addr);
  assign r_held = pr_en && (pr_addr == r_addr);

  // Loser selection: persist previous loser, else incumbent keeps it, else left wins
  always_comb begin
    verdict = VERDICT_NONE;
    if (clash) begin
      if (!l_busy_n_q)               verdict = VERDICT_LEFT;
      else if (!r_busy_n_q)          verdict = VERDICT_RIGHT;
      else if (r_held && !l_held)    verdict = VERDICT_LEFT;
      else                           verdict = VERDICT_RIGHT;
    end
  end

  assign lose_l = (verdict == VERDICT_LEFT);
  assign lose_r = (verdict == VERDICT_RIGHT);

  always_ff @(posedge clk) begin
    if (rst) begin
      pl_en      <= 1'b0;
      pr_en      <= 1'b0;
      pl_addr    <= '0;
      pr_addr    <= '0;
      l_busy_n_q <= 1'b1;
      r_busy_n_q <= 1'b1;
    end else begin
      pl_en      <= l_en;
      pr_en      <= r_en;
      pl_addr    <= l_addr;
      pr_addr    <= r_addr;
      l_busy_n_q <= !lose_l;
      r_busy_n_q <= !lose_r;
    end
  end
endmodule

// File: rtl/dpc_wgate.sv
module dpc_wgate (
  input  logic master,
  input  logic en,
  input  logic we,
  input  logic lose,
  input  logic busy_n_i,
  output logic wr_ok
);
  logic inhibit;
  assign inhibit = master ? lose : !busy_n_i;
  assign wr_ok   = en && we && !inhibit;
endmodule

// File: rtl/dpc_mem.sv
module dpc_mem #(
  parameter int AW = 4,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_en,
  input  logic          a_wr,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_en,
  input  logic          b_wr,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  // Port a written last so it takes precedence on a shared address
  always_ff @(posedge clk) begin
    if (b_wr) store[b_addr] <= b_wdata;
    if (a_wr) store[a_addr] <= a_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_rdata <= '0;
      b_rdata <= '0;
    end else begin
      if (a_en) a_rdata <= store[a_addr];
      if (b_en) b_rdata <= store[b_addr];
    end
  end
endmodule

// File: rtl/dp_collide_ram.sv
module dp_collide_ram #(
  parameter int AW = 4,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          master_mode,
  input  logic          l_en,
  input  logic          l_we,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  input  logic          l_busy_n_i,
  output logic          l_busy_n_o,
  input  logic          r_en,
  input  logic          r_we,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata,
  input  logic          r_busy_n_i,
  output logic          r_busy_n_o
);
  logic lose_l, lose_r;
  logic wr_l, wr_r;

  dpc_arbiter #(.AW(AW)) u_arb (
    .clk        (clk),
    .rst        (rst),
    .master     (master_mode),
    .l_en       (l_en),
    .l_addr     (l_addr),
    .r_en       (r_en),
    .r_addr     (r_addr),
    .lose_l     (lose_l),
    .lose_r     (lose_r),
    .l_busy_n_q (l_busy_n_o),
    .r_busy_n_q (r_busy_n_o)
  );

  dpc_wgate u_gate_l (
    .master   (master_mode),
    .en       (l_en),
    .we       (l_we),
    .lose     (lose_l),
    .busy_n_i (l_busy_n_i),
    .wr_ok    (wr_l)
  );

  dpc_wgate u_gate_r (
    .master   (master_mode),
    .en       (r_en),
    .we       (r_we),
    .lose     (lose_r),
    .busy_n_i (r_busy_n_i),
    .wr_ok    (wr_r)
  );

  dpc_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk     (clk),
    .rst     (rst),
    .a_en    (l_en),
    .a_wr    (wr_l),
    .a_addr  (l_addr),
    .a_wdata (l_wdata),
    .a_rdata (l_rdata),
    .b_en    (r_en),
    .b_wr    (wr_r),
    .b_addr  (r_addr),
    .b_wdata (r_wdata),
    .b_rdata (r_rdata)
  );
endmodule

// File: rtl/dp_collide_ram_chk.sv
module dp_collide_ram_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          master_mode,
  input logic          l_en,
  input logic          l_we,
  input logic [AW-1:0] l_addr,
  input logic          l_busy_n_i,
  input logic          l_busy_n_o,
  input logic          r_en,
  input logic          r_we,
  input logic [AW-1:0] r_addr,
  input logic          r_busy_n_i,
  input logic          r_busy_n_o,
  input logic          wr_l,
  input logic          wr_r
);
  logic hit;
  assign hit = l_en && r_en && (l_addr == r_addr);

  p_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    master_mode && !hit |=> l_busy_n_o && r_busy_n_o);

  p_one_loser_r2: assert property (@(posedge clk) disable iff (rst)
    master_mode && hit |=> $countones({l_busy_n_o, r_busy_n_o}) == 1);

  p_fresh_left_r3: assert property (@(posedge clk) disable iff (rst)
    master_mode && hit && l_busy_n_o && r_busy_n_o && !$past(r_en) |=> !r_busy_n_o);

  p_single_writer_r5: assert property (@(posedge clk) disable iff (rst)
    master_mode && hit |-> !(wr_l && wr_r));

  p_slave_outputs_r8: assert property (@(posedge clk) disable iff (rst)
    !master_mode |=> l_busy_n_o && r_busy_n_o);

  p_slave_inhibit_l_r9: assert property (@(posedge clk) disable iff (rst)
    !master_mode && !l_busy_n_i |-> !wr_l);

  p_slave_inhibit_r_r9: assert property (@(posedge clk) disable iff (rst)
    !master_mode && !r_busy_n_i |-> !wr_r);

  p_master_ignores_in_r10: assert property (@(posedge clk) disable iff (rst)
    master_mode && l_en && l_we && !hit |-> wr_l);
endmodule

bind dp_collide_ram dp_collide_ram_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .master_mode (master_mode),
  .l_en        (l_en),
  .l_we        (l_we),
  .l_addr      (l_addr),
  .l_busy_n_i  (l_busy_n_i),
  .l_busy_n_o  (l_busy_n_o),
  .r_en        (r_en),
  .r_we        (r_we),
  .r_addr      (r_addr),
  .r_busy_n_i  (r_busy_n_i),
  .r_busy_n_o  (r_busy_n_o),
  .wr_l        (wr_l),
  .wr_r        (wr_r)
);

// File: tb/dp_collide_ram_bench.sv
`timescale 1ns/1ps
module dp_collide_ram_bench;
  localparam int AW = 4;
  localparam int DW = 9;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic md = 1'b1;
  logic le = 1'b0, lw = 1'b0, lbi = 1'b1;
  logic re = 1'b0, rw = 1'b0, rbi = 1'b1;
  logic [AW-1:0] la = '0, ra = '0;
  logic [DW-1:0] ld = '0, rd = '0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic l_busy_n_o, r_busy_n_o;

  always #10 clk = ~clk;

  dp_collide_ram #(.AW(AW), .DW(DW)) u_dp_collide_ram (
    .clk(clk), .rst(rst), .master_mode(md),
    .l_en(le), .l_we(lw), .l_addr(la), .l_wdata(ld), .l_rdata(l_rdata),
    .l_busy_n_i(lbi), .l_busy_n_o(l_busy_n_o),
    .r_en(re), .r_we(rw), .r_addr(ra), .r_wdata(rd), .r_rdata(r_rdata),
    .r_busy_n_i(rbi), .r_busy_n_o(r_busy_n_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [DW-1:0] mm [DEPTH];
  logic          e_bl = 1'b1, e_br = 1'b1;
  logic [DW-1:0] e_rl = '0, e_rr = '0;
  logic          p_le = 1'b0, p_re = 1'b0;
  logic [AW-1:0] p_la = '0, p_ra = '0;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Apply current inputs for one edge, predict, then compare after the edge.
  task automatic step(input string rtag);
    bit hit, lose_l, lose_r, fresh, okl, okr;
    string btag, ltag, rtg;
    hit = md && le && re && (la == ra);
    lose_l = 1'b0; lose_r = 1'b0; fresh = 1'b0;
    if (hit) begin
      if (!e_bl) lose_l = 1'b1;
      else if (!e_br) lose_r = 1'b1;
      else if (p_re && p_ra == ra && !(p_le && p_la == la)) lose_l = 1'b1;
      else begin lose_r = 1'b1; fresh = 1'b1; end
    end
    btag = !md ? "R8" : (!hit ? "R1" : (fresh ? "R3" : "R4"));
    ltag = (rtag != "") ? rtag : (lose_l ? "R7" : "R12");
    rtg  = (rtag != "") ? rtag : (lose_r ? "R7" : "R12");
    if (le) e_rl = mm[la];
    if (re) e_rr = mm[ra];
    okl = le && lw && !(md ? lose_l : !lbi);
    okr = re && rw && !(md ? lose_r : !rbi);
    if (okr) mm[ra] = rd;
    if (okl) mm[la] = ld;
    e_bl = !lose_l;
    e_br = !lose_r;
    p_le = le; p_re = re; p_la = la; p_ra = ra;
    @(posedge clk);
    #5;
    chk({btag, " busy_l"}, DW'(l_busy_n_o), DW'(e_bl));
    chk({btag, " busy_r"}, DW'(r_busy_n_o), DW'(e_br));
    chk({ltag, " rdata_l"}, l_rdata, e_rl);
    chk({rtg,  " rdata_r"}, r_rdata, e_rr);
    if (hit) chk("R2 one busy", DW'(int'(!l_busy_n_o) + int'(!r_busy_n_o)), DW'(1));
    @(negedge clk);
  endtask

  task automatic idle();
    le = 1'b0; re = 1'b0; lw = 1'b0; rw = 1'b0;
    step("");
  endtask

  task automatic readback(input string tag);
    for (int a = 0; a < DEPTH; a++) begin
      le = 1'b1; re = 1'b1; lw = 1'b0; rw = 1'b0;
      la = AW'(a); ra = AW'(DEPTH - 1 - a);
      step(tag);
    end
    idle();
  endtask

  initial begin : watchdog
    #(20 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic b6a, b6b;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 busy_l", DW'(l_busy_n_o), DW'(1));
    chk("R11 busy_r", DW'(r_busy_n_o), DW'(1));
    chk("R11 rdata_l", l_rdata, '0);
    chk("R11 rdata_r", r_rdata, '0);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 busy_l after release", DW'(l_busy_n_o), DW'(1));
    chk("R11 rdata_r after release", r_rdata, '0);

    // Fill the array through the left port in slave mode, inhibits released
    md = 1'b0; lbi = 1'b1; rbi = 1'b1;
    for (int a = 0; a < DEPTH; a++) begin
      le = 1'b1; lw = 1'b1; la = AW'(a); ld = DW'(a * 5 + 1);
      re = 1'b0; rw = 1'b0;
      step("");
    end
    idle();

    // R6: same conflict as reads and as writes gives the same busy result
    md = 1'b1;
    le = 1'b1; re = 1'b1; lw = 1'b0; rw = 1'b0; la = 4'd5; ra = 4'd5;
    step("");
    b6a = r_busy_n_o;
    idle();
    le = 1'b1; re = 1'b1; lw = 1'b1; rw = 1'b1; la = 4'd5; ra = 4'd5;
    ld = 9'h1AA; rd = 9'h055;
    step("");
    b6b = r_busy_n_o;
    chk("R6 busy_r read vs write", DW'(b6b), DW'(b6a));
    idle();

    // R4: right holds address 7, left arrives later and must lose
    le = 1'b0; re = 1'b1; rw = 1'b0; ra = 4'd7;
    step("");
    le = 1'b1; lw = 1'b1; la = 4'd7; ld = 9'h123;
    step("");
    chk("R4 newcomer left busy", DW'(l_busy_n_o), DW'(0));
    step("");
    chk("R4 persistent left busy", DW'(l_busy_n_o), DW'(0));
    idle();
    le = 1'b1; lw = 1'b0; la = 4'd7;
    step("");
    chk("R5 word kept after lost write", l_rdata, DW'(7 * 5 + 1));
    idle();

    // Master sweep over a four-word window; busy inputs toggled to show R10
    for (int i = 0; i < 3000; i++) begin
      md = 1'b1;
      le = (i % 5) != 0;  re = (i % 7) != 3;
      lw = (i % 3) == 1;  rw = (i % 4) != 0;
      la = AW'((i / 3) % 4); ra = AW'((i / 5) % 4);
      ld = DW'(i * 7);    rd = DW'(i * 11 + 3);
      lbi = (i % 6) != 0; rbi = (i % 4) != 1;
      step("");
    end
    idle();
    readback("R5");

    // Slave sweep: inhibit inputs decide writes
    for (int i = 0; i < 2000; i++) begin
      md = 1'b0;
      le = (i % 4) != 0;  re = (i % 3) != 2;
      lw = (i % 2) == 0;  rw = (i % 5) != 0;
      la = AW'((i / 2) % 4); ra = AW'((i / 3) % 4);
      ld = DW'(i * 13 + 1); rd = DW'(i * 3 + 2);
      lbi = (i % 3) != 0; rbi = (i % 5) != 1;
      step("");
    end
    idle();
    readback("R9");

    // R9: right inhibit tied low, right writes every word, nothing changes
    md = 1'b0; rbi = 1'b0; lbi = 1'b1;
    for (int a = 0; a < DEPTH; a++) begin
      le = 1'b0; re = 1'b1; rw = 1'b1; ra = AW'(a); rd = 9'h1FF;
      step("");
    end
    idle();
    readback("R9");

    // R12: both write same word in slave mode, left data kept
    rbi = 1'b1;
    le = 1'b1; re = 1'b1; lw = 1'b1; rw = 1'b1; la = 4'd2; ra = 4'd2;
    ld = 9'h0F0; rd = 9'h10F;
    step("");
    le = 1'b1; lw = 1'b0; re = 1'b0; rw = 1'b0;
    step("");
    chk("R12 left write wins", l_rdata, 9'h0F0);
    idle();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule